// File: doc/BRIEF.md
# Black Level Offset Loop

This block holds the black level of one 8-bit video channel at a programmable target. On every line it sums a selectable number of pixels taken from the black clamp window and divides by that count. When the window closes it feeds the error between the target and that average into a slow digital integrator. The integrator's whole part is a signed offset, and that offset is added to every valid pixel of the channel. The sum is clipped to the pixel range.

The black pixels are measured after the offset is added, so the integrator closes a feedback loop. It settles when the corrected black level equals the target. The loop gain is set by a bandwidth field, which gives a time constant of 2^(5+field) lines. When the loop is switched off, a manual 10-bit offset code goes through the same adder and output register instead, and the integrator keeps its value until the loop is switched back on.

Top module: `abl_black_loop`

## Requirements
- R1: While reset is asserted and on the first sample after it is released, `pix_out` is 0, `pix_out_vld` is 0, and the integrator holds zero. With the loop enabled, `ofs_code` then reads 0x200.
- R2: `pix_out` and `pix_out_vld` follow the inputs `pix_in` and `pix_vld` by exactly one clock. This delay is the same with the loop enabled and with the manual offset selected.
- R3: `pix_out` equals `pix_in` plus the signed applied offset, clipped to the range 0 to 255. It does not wrap.
- R4: An offset code is 10 bits with a bias of 0x200, so the signed offset is the code minus 0x200. 0x000 means -512, 0x200 means 0 and 0x3FF means +511. `ofs_code` always shows the code of the offset being applied.
- R5: `cfg_win_sel` selects the number N of black pixels averaged per line: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. A black pixel is a cycle with both `clamp_win` and `pix_vld` high. Only the first N of them in a line are summed, using their corrected values, and the average is that sum divided by N.
- R6: The integrator has 12 fraction bits and updates at the clock edge on which `clamp_win` is sampled low after being high on the edge before. The update adds (`cfg_black_tgt` - average) x 2^(7-`cfg_bw`) in fraction units, and the applied offset is the floor of the integrator divided by 4096. The integrator changes at no other edge.
- R7: `cfg_bw` sets the time constant to 2^(5+`cfg_bw`) lines, from 32 lines at 000 to 4096 lines at 111. The default 100 gives 512 lines. One update never moves the integrator by more than 255 x 2^(7-`cfg_bw`) fraction units.
- R8: If fewer than N black pixels were collected when the window closes, the integrator is left unchanged for that line.
- R9: While `cfg_loop_off` is 1, `cfg_man_code` is the applied offset and the integrator is frozen. When the loop is re-enabled, it resumes from the value it held.
- R10: A cycle with `hsync` high discards the black pixels collected so far in the line, even in the middle of a clamp window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_in | input | 8 | Incoming pixel value |
| pix_vld | input | 1 | Pixel qualifier |
| clamp_win | input | 1 | High during the black clamp window of a line |
| hsync | input | 1 | Line start marker; clears the black pixel collection |
| cfg_loop_off | input | 1 | 1: manual offset, integrator frozen; 0: automatic loop |
| cfg_win_sel | input | 2 | Black pixel count per line (16/32/64/128) |
| cfg_bw | input | 3 | Loop bandwidth; time constant 2^(5+value) lines |
| cfg_black_tgt | input | 8 | Target corrected black level |
| cfg_man_code | input | 10 | Manual offset code, 0x200 is zero |
| pix_out | output | 8 | Corrected, clipped pixel |
| pix_out_vld | output | 1 | Qualifier of `pix_out` |
| ofs_code | output | 10 | Code of the offset currently applied |

## Verification
On every cycle, the assertions check:
- the one-clock delay of data and qualifier;
- the clipped sum against the offset code shown one clock earlier;
- that the integrator moves only just after a clamp window closes, and never while the manual offset is selected;
- that each step stays within the bound set by the bandwidth field.

Other behaviours show only in the bench's scenarios. These are which pixels enter the average (only the first N, and only qualified ones), the skipped update on a short window, the discard on a line marker inside a window, and the exact step sizes for the different window sizes and bandwidth values.

// File: rtl/abl_pkg.sv
package abl_pkg;
    localparam int ABL_PIX_W      = 8;
    localparam int ABL_OFS_W      = 10;
    localparam int ABL_SEL_W      = 2;
    localparam int ABL_BW_W       = 3;
    localparam int ABL_MIN_LOG2   = 4;
    localparam int ABL_BASE_SHIFT = 5;
    localparam int ABL_FRAC_W     = ABL_BASE_SHIFT + (1 << ABL_BW_W) - 1;
    localparam int ABL_ACC_W      = ABL_OFS_W + ABL_FRAC_W;
endpackage

// File: rtl/abl_pix_adder.sv
// Adds the signed offset to the pixel, clips to the pixel range and
// registers the result; the clipped value is also offered unregistered
// so the black measurement sees exactly what leaves the block.
module abl_pix_adder
    import abl_pkg::*;
#(
    parameter int PIX_W = ABL_PIX_W,
    parameter int OFS_W = ABL_OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PIX_W-1:0]        pix_in,
    input  logic                    pix_vld,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [PIX_W-1:0]        corr,
    output logic [PIX_W-1:0]        pix_out,
    output logic                    pix_out_vld
);
    localparam logic signed [OFS_W:0] PIX_MAX = (OFS_W+1)'((1 << PIX_W) - 1);

    typedef struct packed {
        logic [PIX_W-1:0] data;
        logic             vld;
    } add_st_t;

    add_st_t st_d, st_q;
    logic signed [OFS_W:0] sum_w;

    always_comb begin
        sum_w = $signed({{(OFS_W+1-PIX_W){1'b0}}, pix_in}) + $signed({ofs[OFS_W-1], ofs});
        if (sum_w < 0)
            corr = '0;
        else if (sum_w > PIX_MAX)
            corr = '1;
        else
            corr = sum_w[PIX_W-1:0];
        st_d      = st_q;
        st_d.data = corr;
        st_d.vld  = pix_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_out     = st_q.data;
    assign pix_out_vld = st_q.vld;
endmodule

// File: rtl/abl_clamp_avg.sv
// Collects the first N qualified black pixels of a line and presents
// their average, with a strobe, on the cycle the clamp window closes.
module abl_clamp_avg
    import abl_pkg::*;
#(
    parameter int PIX_W    = ABL_PIX_W,
    parameter int SEL_W    = ABL_SEL_W,
    parameter int MIN_LOG2 = ABL_MIN_LOG2,
    localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1,
    localparam int CNT_W    = MAX_LOG2 + 1,
    localparam int SUM_W    = PIX_W + MAX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] px,
    input  logic             px_vld,
    input  logic             clamp,
    input  logic             hsync,
    input  logic [SEL_W-1:0] win_sel,
    output logic             avg_ok,
    output logic [PIX_W-1:0] avg
);
    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic             clamp;
    } avg_st_t;

    avg_st_t st_d, st_q;
    logic [CNT_W-1:0] need;
    logic             win_end;
    int               lg;

    always_comb begin
        lg      = MIN_LOG2 + int'(win_sel);
        need    = CNT_W'(1) << lg;
        win_end = st_q.clamp && !clamp;
        avg_ok  = win_end && (st_q.cnt >= need);
        avg     = PIX_W'(st_q.sum >> lg);

        st_d       = st_q;
        st_d.clamp = clamp;
        if (hsync || win_end) begin
            st_d.sum = '0;
            st_d.cnt = '0;
        end else if (clamp && px_vld && (st_q.cnt < need)) begin
            st_d.sum = st_q.sum + SUM_W'(px);
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/abl_loop_filter.sv
// Integrator with fraction bits: each accepted line adds the black error
// scaled by 2^(7-bw) fraction units; the whole part is the offset.
module abl_loop_filter
    import abl_pkg::*;
#(
    parameter int PIX_W      = ABL_PIX_W,
    parameter int OFS_W      = ABL_OFS_W,
    parameter int BW_W       = ABL_BW_W,
    parameter int BASE_SHIFT = ABL_BASE_SHIFT,
    localparam int FRAC_W = BASE_SHIFT + (1 << BW_W) - 1,
    localparam int ACC_W  = OFS_W + FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic                    hold,
    input  logic [PIX_W-1:0]        avg,
    input  logic [PIX_W-1:0]        target,
    input  logic [BW_W-1:0]         bw,
    output logic signed [OFS_W-1:0] ofs,
    output logic signed [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W:0] ACC_MAX = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] ACC_MIN = {2'b11, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } lf_st_t;

    lf_st_t st_d, st_q;
    logic signed [PIX_W:0] err;
    logic signed [ACC_W:0] step, sum_x;
    int                    sh;

    always_comb begin
        err   = $signed({1'b0, target}) - $signed({1'b0, avg});
        sh    = FRAC_W - BASE_SHIFT - int'(bw);
        step  = {{(ACC_W-PIX_W){err[PIX_W]}}, err};
        step  = step <<< sh;
        sum_x = {st_q.acc[ACC_W-1], st_q.acc} + step;

        st_d = st_q;
        if (upd && !hold) begin
            if (sum_x > ACC_MAX)
                st_d.acc = ACC_MAX[ACC_W-1:0];
            else if (sum_x < ACC_MIN)
                st_d.acc = ACC_MIN[ACC_W-1:0];
            else
                st_d.acc = sum_x[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;
    assign ofs = st_q.acc[ACC_W-1:FRAC_W];
endmodule

// File: rtl/abl_black_loop.sv
module abl_black_loop
    import abl_pkg::*;
#(
    parameter int PIX_W      = ABL_PIX_W,
    parameter int OFS_W      = ABL_OFS_W,
    parameter int SEL_W      = ABL_SEL_W,
    parameter int BW_W       = ABL_BW_W,
    parameter int MIN_LOG2   = ABL_MIN_LOG2,
    parameter int BASE_SHIFT = ABL_BASE_SHIFT,
    localparam int FRAC_W = BASE_SHIFT + (1 << BW_W) - 1,
    localparam int ACC_W  = OFS_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             pix_vld,
    input  logic             clamp_win,
    input  logic             hsync,
    input  logic             cfg_loop_off,
    input  logic [SEL_W-1:0] cfg_win_sel,
    input  logic [BW_W-1:0]  cfg_bw,
    input  logic [PIX_W-1:0] cfg_black_tgt,
    input  logic [OFS_W-1:0] cfg_man_code,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_out_vld,
    output logic [OFS_W-1:0] ofs_code
);
    logic [PIX_W-1:0]        corr;
    logic [PIX_W-1:0]        avg;
    logic                    avg_ok;
    logic signed [OFS_W-1:0] loop_ofs, man_ofs, ofs_apply;
    logic signed [ACC_W-1:0] loop_acc;

    // biased code <-> two's complement is an MSB flip
    always_comb begin
        man_ofs   = {~cfg_man_code[OFS_W-1], cfg_man_code[OFS_W-2:0]};
        ofs_apply = cfg_loop_off ? man_ofs : loop_ofs;
        ofs_code  = {~ofs_apply[OFS_W-1], ofs_apply[OFS_W-2:0]};
    end

    abl_pix_adder #(.PIX_W(PIX_W), .OFS_W(OFS_W)) u_add (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld),
        .ofs(ofs_apply), .corr(corr), .pix_out(pix_out), .pix_out_vld(pix_out_vld)
    );

    abl_clamp_avg #(.PIX_W(PIX_W), .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_avg (
        .clk(clk), .rst_n(rst_n), .px(corr), .px_vld(pix_vld), .clamp(clamp_win),
        .hsync(hsync), .win_sel(cfg_win_sel), .avg_ok(avg_ok), .avg(avg)
    );

    abl_loop_filter #(.PIX_W(PIX_W), .OFS_W(OFS_W), .BW_W(BW_W), .BASE_SHIFT(BASE_SHIFT)) u_lf (
        .clk(clk), .rst_n(rst_n), .upd(avg_ok), .hold(cfg_loop_off), .avg(avg),
        .target(cfg_black_tgt), .bw(cfg_bw), .ofs(loop_ofs), .acc(loop_acc)
    );
endmodule

// File: rtl/abl_black_loop_chk.sv
module abl_black_loop_chk
    import abl_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [ABL_PIX_W-1:0]        pix_in,
    input logic                        pix_vld,
    input logic                        clamp_win,
    input logic                        cfg_loop_off,
    input logic [ABL_BW_W-1:0]         cfg_bw,
    input logic [ABL_PIX_W-1:0]        pix_out,
    input logic                        pix_out_vld,
    input logic [ABL_OFS_W-1:0]        ofs_code,
    input logic signed [ABL_ACC_W-1:0] loop_acc
);
    localparam int BIAS = 1 << (ABL_OFS_W - 1);
    localparam int PMAX = (1 << ABL_PIX_W) - 1;

    logic armed_q, clamp_q, win_end_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            clamp_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            clamp_q <= clamp_win;
        end
    end

    assign win_end_c = clamp_q && !clamp_win;

    function automatic int exp_pix(input logic [ABL_PIX_W-1:0] p, input logic [ABL_OFS_W-1:0] c);
        int s;
        s = int'(p) + int'(c) - BIAS;
        if (s < 0) s = 0;
        if (s > PMAX) s = PMAX;
        return s;
    endfunction

    function automatic int abs_diff(input logic signed [ABL_ACC_W-1:0] a, input logic signed [ABL_ACC_W-1:0] b);
        int d;
        d = int'(a) - int'(b);
        return (d < 0) ? -d : d;
    endfunction

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        pix_out_vld == $past(pix_vld));

    assert_clip_sum_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        int'(pix_out) == exp_pix($past(pix_in), $past(ofs_code)));

    assert_update_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$stable(loop_acc) |-> $past(win_end_c));

    assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        abs_diff(loop_acc, $past(loop_acc)) <= (PMAX << (ABL_FRAC_W - ABL_BASE_SHIFT - int'($past(cfg_bw)))));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(cfg_loop_off) |-> $stable(loop_acc));
endmodule

bind abl_black_loop abl_black_loop_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld), .clamp_win(clamp_win),
    .cfg_loop_off(cfg_loop_off), .cfg_bw(cfg_bw), .pix_out(pix_out), .pix_out_vld(pix_out_vld),
    .ofs_code(ofs_code), .loop_acc(loop_acc)
);

// File: tb/sim_abl_black_loop.sv
module sim_abl_black_loop;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_in = '0;
    logic       pix_vld = 1'b0;
    logic       clamp_win = 1'b0;
    logic       hsync = 1'b0;
    logic       cfg_loop_off = 1'b0;
    logic [1:0] cfg_win_sel = 2'b00;
    logic [2:0] cfg_bw = 3'b100;
    logic [7:0] cfg_black_tgt = 8'd16;
    logic [9:0] cfg_man_code = 10'h200;
    logic [7:0] pix_out;
    logic       pix_out_vld;
    logic [9:0] ofs_code;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;
    string cur_req = "R3";

    // behavioural reference state
    int m_acc, m_sum, m_cnt, m_out;
    bit m_cprev, m_vld;

    abl_black_loop u0 (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_vld(pix_vld), .clamp_win(clamp_win),
        .hsync(hsync), .cfg_loop_off(cfg_loop_off), .cfg_win_sel(cfg_win_sel), .cfg_bw(cfg_bw),
        .cfg_black_tgt(cfg_black_tgt), .cfg_man_code(cfg_man_code),
        .pix_out(pix_out), .pix_out_vld(pix_out_vld), .ofs_code(ofs_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        int ofs, c, lg, need, err;
        if (!rst_n) begin
            m_acc = 0; m_sum = 0; m_cnt = 0; m_out = 0; m_vld = 0; m_cprev = 0;
        end else begin
            ofs = cfg_loop_off ? (int'(cfg_man_code) - 512) : (m_acc >>> 12);
            c = int'(pix_in) + ofs;
            if (c < 0) c = 0;
            if (c > 255) c = 255;
            lg = 4 + int'(cfg_win_sel);
            need = 1 << lg;
            if (m_cprev && !clamp_win && m_cnt >= need && !cfg_loop_off) begin
                err = int'(cfg_black_tgt) - (m_sum >> lg);
                m_acc = m_acc + err * (1 << (7 - int'(cfg_bw)));
                if (m_acc > 2097151) m_acc = 2097151;
                if (m_acc < -2097152) m_acc = -2097152;
            end
            if (hsync || (m_cprev && !clamp_win)) begin
                m_sum = 0; m_cnt = 0;
            end else if (clamp_win && pix_vld && m_cnt < need) begin
                m_sum = m_sum + c; m_cnt = m_cnt + 1;
            end
            m_cprev = clamp_win;
            m_out = c;
            m_vld = pix_vld;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        int mc;
        @(negedge clk);
        mc = cfg_loop_off ? int'(cfg_man_code) : ((m_acc >>> 12) + 512);
        chk(cur_req, "pix_out", int'(pix_out), m_out);
        chk(cur_req, "pix_out_vld", int'(pix_out_vld), int'(m_vld));
        chk(cur_req, "ofs_code", int'(ofs_code), mc);
    endtask

    task automatic do_reset();
        rst_n = 0;
        pix_vld = 0; clamp_win = 0; hsync = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic run_line(input int nclamp, input int nfirst, input int b1, input int b2, input int nact);
        cyc(); hsync = 1; pix_vld = 0; clamp_win = 0;
        cyc(); hsync = 0;
        cyc();
        for (int i = 0; i < nclamp; i++) begin
            if (i % 7 == 3) begin
                cyc(); clamp_win = 1; pix_vld = 0; pix_in = 8'd255;
            end
            cyc(); clamp_win = 1; pix_vld = 1; pix_in = 8'((i < nfirst) ? b1 : b2);
        end
        cyc(); clamp_win = 0; pix_vld = 0;
        cyc();
        cyc();
        for (int i = 0; i < nact; i++) begin
            cyc(); pix_vld = 1; pix_in = 8'($urandom_range(255, 0));
        end
        cyc(); pix_vld = 0;
        cyc();
    endtask

    task automatic probe(input int v, input int exp, input string req);
        pix_in = 8'(v); pix_vld = 1;
        cyc();
        chk(req, "probe pix_out", int'(pix_out), exp);
        chk("R2", "probe pix_out_vld", int'(pix_out_vld), 1);
        pix_vld = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        do_reset();
        chk("R1", "pix_out", int'(pix_out), 0);
        chk("R1", "pix_out_vld", int'(pix_out_vld), 0);
        chk("R1", "ofs_code", int'(ofs_code), 'h200);

        // R6: one fast update, black 40 vs target 16
        cur_req = "R6";
        cfg_bw = 3'd0; cfg_win_sel = 2'd0; cfg_black_tgt = 8'd16;
        run_line(20, 20, 40, 40, 20);
        chk("R6", "first step code", int'(ofs_code), 'h1FF);
        for (int k = 0; k < 30; k++) run_line(20, 20, 40, 40, 20);

        // R7: bandwidth extremes
        cur_req = "R7";
        do_reset();
        cfg_bw = 3'd0; cfg_black_tgt = 8'd255;
        run_line(16, 16, 0, 0, 10);
        chk("R7", "bw=000 one line", int'(ofs_code), 'h207);
        do_reset();
        cfg_bw = 3'd7;
        for (int k = 0; k < 16; k++) run_line(16, 16, 0, 0, 10);
        chk("R7", "bw=111 after 16 lines", int'(ofs_code), 'h200);
        run_line(16, 16, 0, 0, 10);
        chk("R7", "bw=111 after 17 lines", int'(ofs_code), 'h201);

        // R5: window sizes and first-N selection
        cur_req = "R5";
        do_reset();
        cfg_bw = 3'd0; cfg_black_tgt = 8'd16; cfg_win_sel = 2'd1;
        run_line(40, 32, 48, 200, 10);
        chk("R5", "32 px first-N", int'(ofs_code), 'h1FF);
        do_reset();
        cfg_win_sel = 2'd2;
        run_line(64, 64, 144, 144, 10);
        chk("R5", "64 px", int'(ofs_code), 'h1FC);
        do_reset();
        cfg_win_sel = 2'd3;
        run_line(128, 128, 80, 80, 10);
        chk("R5", "128 px", int'(ofs_code), 'h1FE);

        // R8: short windows leave the integrator alone
        cur_req = "R8";
        do_reset();
        cfg_win_sel = 2'd3;
        run_line(100, 100, 80, 80, 10);
        chk("R8", "100 of 128", int'(ofs_code), 'h200);
        cfg_win_sel = 2'd1;
        run_line(31, 31, 80, 80, 10);
        chk("R8", "31 of 32", int'(ofs_code), 'h200);

        // R10: line marker inside the window discards collected pixels
        cur_req = "R10";
        do_reset();
        cfg_win_sel = 2'd0;
        cyc(); hsync = 1;
        cyc(); hsync = 0;
        for (int i = 0; i < 10; i++) begin cyc(); clamp_win = 1; pix_vld = 1; pix_in = 8'd48; end
        cyc(); pix_vld = 0; hsync = 1;
        cyc(); hsync = 0;
        for (int i = 0; i < 10; i++) begin cyc(); pix_vld = 1; pix_in = 8'd48; end
        cyc(); clamp_win = 0; pix_vld = 0;
        cyc(); cyc();
        chk("R10", "split window", int'(ofs_code), 'h200);

        // R9: manual offset, frozen integrator, resume
        cur_req = "R9";
        do_reset();
        cfg_bw = 3'd0; cfg_win_sel = 2'd0; cfg_black_tgt = 8'd16;
        run_line(16, 16, 48, 48, 10);
        chk("R9", "loop code before off", int'(ofs_code), 'h1FF);
        cfg_loop_off = 1; cfg_man_code = 10'h205;
        cyc();
        chk("R9", "manual code shown", int'(ofs_code), 'h205);
        for (int k = 0; k < 3; k++) run_line(16, 16, 48, 48, 10);
        cur_req = "R4";
        cfg_man_code = 10'h000; cyc();
        probe(100, 0, "R4");
        cfg_man_code = 10'h3FF; cyc();
        probe(100, 255, "R4");
        cfg_man_code = 10'h205; cyc();
        probe(100, 105, "R2");
        cur_req = "R9";
        cfg_loop_off = 0;
        cyc();
        chk("R9", "resumed code", int'(ofs_code), 'h1FF);
        cur_req = "R3";
        probe(0, 0, "R3");
        probe(255, 254, "R3");
        probe(77, 76, "R3");
        run_line(16, 16, 48, 48, 10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule